// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Flag

This block moves a stream of words from a write clock domain to an unrelated read clock domain through a 16-entry register array. Each side keeps its own Gray-coded position pointer, and each side sees the other side's pointer through a short synchronizer chain. When the two pointers match, the FIFO is either completely full or completely empty. The pointers carry no extra lap bit to tell these two cases apart. Instead, one set/reset direction bit records which way the pointers last approached each other. That bit is updated by comparing the two most significant pointer bits, which form a 2-bit Gray quadrant number.

The write side is a valid/ready sink. A word transfers on a rising write clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops while the write side considers the FIFO full. A producer may keep `in_valid` high with stable data while waiting; it is not required to. The read side is a valid/ready source. `out_data` is meaningful only while `out_valid` is high. A word leaves on a rising read clock edge where `out_valid` and `out_ready` are both high. Both status signals are conservative: each side may briefly report less room or less data than the true occupancy, while the other side's pointer is still in its synchronizer.

Top module: `qfifo_quad`

## Requirements
- R1: While reset is held low and after its release, with no traffic, `in_ready` is 1 and `out_valid` is 0.
- R2: Words leave in exactly the order in which they were accepted, none lost and none duplicated.
- R3: With no reads, exactly 16 words are accepted, and `in_ready` then stays 0.
- R4: A word offered while `in_ready` is 0 is not stored: a later full drain yields only the accepted words.
- R5: Asserting `out_ready` while `out_valid` is 0 removes nothing: later reads still deliver every stored word in order.
- R6: `in_ready` is never 1 while 16 words are stored, and `out_valid` is never 1 while nothing is stored.
- R7: After both sides have been idle for 8 clocks of each domain, `in_ready` is 1 exactly when fewer than 16 words are stored, and `out_valid` is 1 exactly when at least one word is stored.
- R8: Both pointers are 4-bit Gray counters that change one bit per step. Their top two bits are the quadrant. The direction bit is set when the read quadrant is one ahead of the write quadrant (modulo 4) and cleared when it is one behind. Otherwise it holds. On pointer equality a set bit means full and a clear bit means empty, so after 16 pushes the FIFO reports full and after the drain it reports empty, on every pass around the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | FIFO can take a word this write cycle |
| in_data | input | DATA_W | Word offered by the producer |
| out_valid | output | 1 | A word is present on `out_data` |
| out_ready | input | 1 | Consumer takes the word this read cycle |
| out_data | output | DATA_W | Oldest stored word |

## Verification
A push and a pop can land close together, or in the same instant, while the pointers sit in neighbouring quadrants. In that situation one domain's direction copy may be updating just as the other domain's pointer view changes. The bench provokes this with long runs of random traffic under two non-harmonic read clock periods, one slower and one faster than the write clock. A behavioural queue judges every read word and checks both status outputs on every clock of its domain, so no false ready or false valid can pass. Repeated fill-to-full and drain-to-empty passes start at shifted pointer offsets, so that equality is reached from both directions in different quadrants.

// File: rtl/qfq_pkg.sv
`timescale 1ns/1ps
package qfq_pkg;

  localparam int QUAD_W = 2;

  typedef enum logic [1:0] {
    REL_HOLD = 2'd0,
    REL_SET  = 2'd1,
    REL_CLR  = 2'd2
  } quad_rel_e;

  // 2-bit Gray quadrant to its binary index
  function automatic logic [QUAD_W-1:0] quad_index(input logic [QUAD_W-1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  // Read ahead of write by one quadrant -> set, behind by one -> clear
  function automatic quad_rel_e quad_relation(input logic [QUAD_W-1:0] wr_q,
                                              input logic [QUAD_W-1:0] rd_q);
    logic [QUAD_W-1:0] gap;
    gap = quad_index(rd_q) - quad_index(wr_q);
    if (gap == 2'd1)      return REL_SET;
    else if (gap == 2'd3) return REL_CLR;
    else                  return REL_HOLD;
  endfunction

endpackage

// File: rtl/qfq_gray_ptr.sv
`timescale 1ns/1ps
module qfq_gray_ptr #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [PTR_W-1:0] bin,
  output logic [PTR_W-1:0] gray
);

  logic [PTR_W-1:0] bin_q;
  logic [PTR_W-1:0] gray_q;
  logic [PTR_W-1:0] bin_nx;

  assign bin_nx = bin_q + {{(PTR_W-1){1'b0}}, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= bin_nx ^ (bin_nx >> 1);
    end
  end

  assign bin  = bin_q;
  assign gray = gray_q;

  // R8: crossing value never has more than one changing bit
  a_r8_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);

  // R2: every accepted step moves the pointer
  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (gray_q != $past(gray_q)));

endmodule

// File: rtl/qfq_sync.sv
`timescale 1ns/1ps
module qfq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    logic [W-1:0] r;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= g_st[i-1].r;
      end
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/qfq_dir_flag.sv
`timescale 1ns/1ps
module qfq_dir_flag
  import qfq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QUAD_W-1:0] wr_quad,
  input  logic [QUAD_W-1:0] rd_quad,
  output logic              toward_full
);

  quad_rel_e rel;
  assign rel = quad_relation(wr_quad, rd_quad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toward_full <= 1'b0;
    end else begin
      unique case (rel)
        REL_SET: toward_full <= 1'b1;
        REL_CLR: toward_full <= 1'b0;
        default: toward_full <= toward_full;
      endcase
    end
  end

  // R8: direction follows the quadrant relation one clock later
  a_r8_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_index(rd_quad) == quad_index(wr_quad) + 2'd1) |=> toward_full);

  a_r8_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_index(wr_quad) == quad_index(rd_quad) + 2'd1) |=> !toward_full);

  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_index(rd_quad) - quad_index(wr_quad) inside {2'd0, 2'd2}) |=> $stable(toward_full));

endmodule

// File: rtl/qfq_regfile.sv
`timescale 1ns/1ps
module qfq_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/qfifo_quad.sv
`timescale 1ns/1ps
module qfifo_quad
  import qfq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int QTOP  = PTR_W - 1;

  // ---------------- write domain ----------------
  logic             wr_fire;
  logic [PTR_W-1:0] wr_bin, wr_gray, rd_gray_w;
  logic             dir_w, full_w;

  assign wr_fire = in_valid && in_ready;

  qfq_gray_ptr #(.PTR_W(PTR_W)) u_wptr (
    .clk(wr_clk), .rst_n(arst_n), .step(wr_fire), .bin(wr_bin), .gray(wr_gray)
  );

  qfq_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(wr_clk), .rst_n(arst_n), .d(rd_gray), .q(rd_gray_w)
  );

  qfq_dir_flag u_dir_w (
    .clk(wr_clk), .rst_n(arst_n),
    .wr_quad(wr_gray[QTOP -: QUAD_W]), .rd_quad(rd_gray_w[QTOP -: QUAD_W]),
    .toward_full(dir_w)
  );

  assign full_w   = (wr_gray == rd_gray_w) && dir_w;
  assign in_ready = !full_w;

  // ---------------- read domain ----------------
  logic             rd_fire;
  logic [PTR_W-1:0] rd_bin, rd_gray, wr_gray_r;
  logic             dir_r, empty_r;

  assign rd_fire = out_valid && out_ready;

  qfq_gray_ptr #(.PTR_W(PTR_W)) u_rptr (
    .clk(rd_clk), .rst_n(arst_n), .step(rd_fire), .bin(rd_bin), .gray(rd_gray)
  );

  qfq_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(rd_clk), .rst_n(arst_n), .d(wr_gray), .q(wr_gray_r)
  );

  qfq_dir_flag u_dir_r (
    .clk(rd_clk), .rst_n(arst_n),
    .wr_quad(wr_gray_r[QTOP -: QUAD_W]), .rd_quad(rd_gray[QTOP -: QUAD_W]),
    .toward_full(dir_r)
  );

  assign empty_r   = (rd_gray == wr_gray_r) && !dir_r;
  assign out_valid = !empty_r;

  // ---------------- storage ----------------
  qfq_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_bin), .wdata(in_data),
    .raddr(rd_bin), .rdata(out_data)
  );

  // R4: an offer refused for lack of room leaves the write pointer alone
  a_r4_hold_when_full: assert property (@(posedge wr_clk) disable iff (!arst_n)
    (in_valid && !in_ready) |=> $stable(wr_gray));

  // R5: a take request with nothing present leaves the read pointer alone
  a_r5_hold_when_empty: assert property (@(posedge rd_clk) disable iff (!arst_n)
    (out_ready && !out_valid) |=> $stable(rd_gray));

endmodule

// File: tb/sim_qfifo_quad.sv
`timescale 1ns/1ps
module sim_qfifo_quad;

  localparam int DW    = 8;
  localparam int DEPTH = 16;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  logic arst_n = 1'b0;
  real  rd_half = 6.85;

  always #4 wr_clk = ~wr_clk;          // 125 MHz
  always #(rd_half) rd_clk = ~rd_clk;

  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  qfifo_quad #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  logic [DW-1:0] model[$];
  int n_chk = 0;
  int n_bad = 0;
  int accepted = 0;
  int taken = 0;
  bit done = 0;

  task automatic note(input bit ok, input string req, input string what,
                      input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cycle(input bit v, input logic [DW-1:0] d);
    @(negedge wr_clk);
    note(!in_ready || model.size() < DEPTH, "R6", "in_ready with model full",
         model.size(), DEPTH - 1);
    in_valid = v;
    in_data  = d;
    if (v && in_ready) begin
      model.push_back(d);
      accepted++;
    end
  endtask

  task automatic rd_cycle(input bit r);
    @(negedge rd_clk);
    note(!out_valid || model.size() > 0, "R6", "out_valid with model empty",
         model.size(), 1);
    out_ready = r;
    if (r && out_valid && model.size() > 0) begin
      note(out_data == model[0], "R2", "read word", int'(out_data), int'(model[0]));
      void'(model.pop_front());
      taken++;
    end
  endtask

  task automatic settle();
    in_valid  = 1'b0;
    out_ready = 1'b0;
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic status_check(input string req);
    @(negedge wr_clk);
    note(in_ready == (model.size() < DEPTH), req, "in_ready after idle",
         int'(in_ready), int'(model.size() < DEPTH));
    @(negedge rd_clk);
    note(out_valid == (model.size() > 0), req, "out_valid after idle",
         int'(out_valid), int'(model.size() > 0));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      summary();
      $finish;
    end
  end

  initial begin
    int a0;
    int t0;
    // R1: reset state
    repeat (3) @(negedge wr_clk);
    note(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    note(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    arst_n = 1'b1;
    repeat (4) @(negedge wr_clk);
    note(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    @(negedge rd_clk);
    note(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R5: reads requested while empty take nothing
    t0 = taken;
    for (int k = 0; k < 20; k++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    note(taken == t0, "R5", "words taken while empty", taken - t0, 0);
    for (int k = 0; k < 5; k++) wr_cycle(1'b1, DW'(8'hA0 + k));
    wr_cycle(1'b0, '0);
    for (int k = 0; k < 30; k++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    note(taken - t0 == 5, "R5", "words read after empty requests", taken - t0, 5);

    // R3/R4/R8: fill and drain several laps from shifted offsets
    for (int lap = 0; lap < 3; lap++) begin
      a0 = accepted;
      for (int k = 0; k < 20; k++) wr_cycle(1'b1, DW'(lap * 40 + k));
      note(accepted - a0 == DEPTH, "R3", "words accepted into idle FIFO",
           accepted - a0, DEPTH);
      for (int k = 0; k < 6; k++) wr_cycle(1'b1, DW'(8'hEE));
      note(accepted - a0 == DEPTH, "R4", "offers while full stored",
           accepted - a0, DEPTH);
      wr_cycle(1'b0, '0);
      settle();
      @(negedge wr_clk);
      note(in_ready == 1'b0, "R3", "in_ready when full", int'(in_ready), 0);
      @(negedge rd_clk);
      note(out_valid == 1'b1, "R8", "equal pointers read as full", int'(out_valid), 1);
      t0 = taken;
      for (int k = 0; k < 40; k++) rd_cycle(1'b1);
      rd_cycle(1'b0);
      note(taken - t0 == DEPTH, "R4", "words drained after refused offers",
           taken - t0, DEPTH);
      settle();
      @(negedge rd_clk);
      note(out_valid == 1'b0, "R8", "equal pointers read as empty", int'(out_valid), 0);
      @(negedge wr_clk);
      note(in_ready == 1'b1, "R7", "room after drain", int'(in_ready), 1);
      // shift pointer offsets for the next lap
      for (int k = 0; k < 3 + lap; k++) wr_cycle(1'b1, DW'(8'h70 + k));
      wr_cycle(1'b0, '0);
      for (int k = 0; k < 20; k++) rd_cycle(1'b1);
      rd_cycle(1'b0);
    end

    // random traffic, read clock slower than write clock
    fork
      begin
        for (int k = 0; k < 3000; k++) wr_cycle(($urandom % 10) < 6, DW'($urandom));
        wr_cycle(1'b0, '0);
      end
      begin
        for (int k = 0; k < 1750; k++) rd_cycle(($urandom % 10) < 6);
        rd_cycle(1'b0);
      end
    join
    settle();
    status_check("R7");

    // random traffic, read clock faster than write clock
    rd_half = 2.9;
    settle();
    fork
      begin
        for (int k = 0; k < 3000; k++) wr_cycle(($urandom % 10) < 8, DW'($urandom));
        wr_cycle(1'b0, '0);
      end
      begin
        for (int k = 0; k < 4100; k++) rd_cycle(($urandom % 10) < 3);
        rd_cycle(1'b0);
      end
    join
    settle();
    status_check("R7");

    // final drain
    for (int k = 0; k < 80; k++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    settle();
    note(model.size() == 0, "R2", "words left undelivered", model.size(), 0);
    note(accepted == taken, "R2", "words delivered", taken, accepted);
    status_check("R7");

    done = 1;
    summary();
    $finish;
  end

endmodule